// File: doc/BRIEF.md
# Incremental Quadrature and Index Output Generator

This block converts an absolute angle, delivered as a 12-bit word, into the incremental signals a counter expects: two quadrature lines, A and B, and an index line, Z. Internally it holds an output count that follows the latest accepted angle. The count moves one step at a time and takes the shorter way around the circle. Each step changes exactly one of A or B. Steps are paced so that consecutive edges never come closer together than a selected minimum spacing. When the requested angle runs ahead of that spacing, the backlog is simply the remaining difference between the target and the output count, so no steps are lost.

When the direction of travel reverses, the block waits until the target has moved two counts back before it emits the first edge of the return. This gives a one-count hysteresis band and keeps jitter on the angle input from producing edge chatter. An invert option mirrors the angle before it is used, which reverses the sense of rotation. The index position can be set in 256 steps around the circle.

Two power-up behaviours are available. In hold mode, A, B and Z all sit at 1 until the first angle arrives, and the lines then show that angle directly. In replay mode, the lines start at count 0 and walk edge by edge to the first angle, so an attached counter ends up with the absolute value.

The angle input is a valid/ready stream. `pos_ready` is always high, so the block never applies back-pressure. A word is taken in every cycle in which `pos_valid` is high, and each accepted word replaces the previous target.

Top module: `abz_quad_gen`

## Requirements
- R1: `pos_ready` is always 1. An angle word is taken only in a cycle with `pos_valid` high. Each accepted word replaces the target, and `pos_data` has no effect while `pos_valid` is low.
- R2: The output count c drives (A,B) = 00, 01, 11, 10 for c mod 4 = 0, 1, 2, 3. Outside startup hold, no cycle changes both A and B.
- R3: The output count steps by one toward the target until the two are equal. It takes the shorter way around the 4096-count circle, and a difference of exactly half a turn is covered by counting down.
- R4: Reversal hysteresis. After a last step upward, a target one count below the output produces no edge, and a target two or more below makes the count step down until it reaches the target. The mirror rule applies after a last step downward.
- R5: Consecutive edges are at least G cycles apart, where G = max(1, floor(T·CLK_MHZ/1000)). T is 500 ns, 125 ns, 8000 ns or 2000 ns for `cfg_gap_sel` = 0, 1, 2, 3. While steps are pending, edges come exactly G cycles apart.
- R6: Z is 1 exactly while the running count equals `cfg_index`·16 + 2, which is a state with A = B = 1. Z is never 1 unless A and B are both 1.
- R7: With `cfg_invert` = 1, the target is (4096 − `pos_data`) mod 4096.
- R8: Hold mode (`cfg_startup_replay` = 0). From reset until the first accepted word takes effect, A = B = Z = 1. After that, the lines show the accepted angle with no edges in between.
- R9: Replay mode (`cfg_startup_replay` = 1). After reset, A = B = Z = 0. After the first word, edges walk the count from 0 to the target without hysteresis, and Z stays 0 until the count has reached the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pos_data | input | 12 | Absolute angle word |
| pos_valid | input | 1 | Angle word valid |
| pos_ready | output | 1 | Always 1, no back-pressure |
| cfg_gap_sel | input | 2 | Minimum edge spacing select |
| cfg_invert | input | 1 | Mirror the angle (reverse the sense of rotation) |
| cfg_index | input | 8 | Index position in 1/256-turn steps |
| cfg_startup_replay | input | 1 | 0 = hold lines high at power-up, 1 = replay edges |
| out_a | output | 1 | Quadrature line A |
| out_b | output | 1 | Quadrature line B |
| out_z | output | 1 | Index line |

## Verification
The bench decodes A and B into its own count and checks it against the expected target. It covers a half-turn request, which a design with the wrong tie rule would cover by counting up, and the reversal band, where a design without hysteresis would emit an edge for a one-count wobble. Each spacing select is timed by its minimum edge distance, which catches a wrong or swapped spacing constant. Full turns in both directions at three index settings confirm that Z fires exactly once per turn at the programmed count. Both startup modes are checked: a stray Z during replay, or an early or double edge at hold release, is reported.

// File: rtl/abz_pkg.sv
`timescale 1ns/1ps
package abz_pkg;

  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_CATCH = 2'd1,
    ST_RUN   = 2'd2
  } start_e;

  // spacing in ns for each select code
  function automatic int unsigned gap_ns(input logic [1:0] sel);
    case (sel)
      2'd0:    return 500;
      2'd1:    return 125;
      2'd2:    return 8000;
      default: return 2000;
    endcase
  endfunction

  function automatic int unsigned gap_cycles(input logic [1:0] sel, input int unsigned mhz);
    int unsigned c;
    c = gap_ns(sel) * mhz / 1000;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int unsigned gap_max(input int unsigned mhz);
    int unsigned m;
    m = 1;
    for (int s = 0; s < 4; s++)
      if (gap_cycles(2'(s), mhz) > m) m = gap_cycles(2'(s), mhz);
    return m;
  endfunction

endpackage

// File: rtl/abz_target.sv
`timescale 1ns/1ps
module abz_target #(
  parameter int POS_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [POS_W-1:0] pos_data,
  input  logic             pos_valid,
  input  logic             cfg_invert,
  output logic [POS_W-1:0] tgt,
  output logic             tgt_ok
);
  logic [POS_W-1:0] mirrored;
  assign mirrored = ~pos_data + {{(POS_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt    <= '0;
      tgt_ok <= 1'b0;
    end else if (pos_valid) begin
      tgt    <= cfg_invert ? mirrored : pos_data;
      tgt_ok <= 1'b1;
    end
  end
endmodule

// File: rtl/abz_pace.sv
`timescale 1ns/1ps
module abz_pace import abz_pkg::*; #(
  parameter int unsigned CLK_MHZ = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] gap_sel,
  input  logic       step,
  output logic       open
);
  localparam int unsigned GMAX = gap_max(CLK_MHZ);
  localparam int CW = (GMAX < 2) ? 1 : $clog2(GMAX + 1);

  logic [CW-1:0] lut [4];
  logic [CW-1:0] cnt;

  for (genvar g = 0; g < 4; g++) begin : g_lut
    assign lut[g] = CW'(gap_cycles(2'(g), CLK_MHZ));
  end

  // after a step, block further steps for gap-1 cycles
  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (step)
      cnt <= lut[gap_sel] - CW'(1);
    else if (cnt != '0)
      cnt <= cnt - CW'(1);
  end

  assign open = (cnt == '0);
endmodule

// File: rtl/abz_stepper.sv
`timescale 1ns/1ps
module abz_stepper import abz_pkg::*; #(
  parameter int POS_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [POS_W-1:0] tgt,
  input  logic             tgt_ok,
  input  logic             open,
  input  logic             cfg_replay,
  output logic [POS_W-1:0] op,
  output start_e           state,
  output logic             step
);
  localparam logic signed [POS_W-1:0] S_ZERO = '0;
  localparam logic signed [POS_W-1:0] S_ONE  = {{(POS_W-1){1'b0}}, 1'b1};
  localparam logic signed [POS_W-1:0] S_MONE = '1;

  logic                    dir_up;
  logic signed [POS_W-1:0] d;
  logic                    up_req;
  logic                    dn_req;

  always_comb begin
    d      = $signed(tgt - op);
    up_req = 1'b0;
    dn_req = 1'b0;
    case (state)
      ST_CATCH: begin
        up_req = d > S_ZERO;
        dn_req = d < S_ZERO;
      end
      ST_RUN: begin
        up_req = dir_up ? (d > S_ZERO) : (d > S_ONE);
        dn_req = dir_up ? (d < S_MONE) : (d < S_ZERO);
      end
      default: ;
    endcase
    step = open && (up_req || dn_req);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op     <= '0;
      dir_up <= 1'b1;
      state  <= ST_WAIT;
    end else begin
      case (state)
        ST_WAIT: begin
          if (tgt_ok) begin
            if (cfg_replay) state <= ST_CATCH;
            else begin
              op    <= tgt;
              state <= ST_RUN;
            end
          end
        end
        ST_CATCH: begin
          if (tgt == op) state <= ST_RUN;
          else if (step) begin
            op     <= up_req ? op + 1'b1 : op - 1'b1;
            dir_up <= up_req;
          end
        end
        ST_RUN: begin
          if (step) begin
            op     <= up_req ? op + 1'b1 : op - 1'b1;
            dir_up <= up_req;
          end
        end
        default: state <= ST_WAIT;
      endcase
    end
  end
endmodule

// File: rtl/abz_encode.sv
`timescale 1ns/1ps
module abz_encode import abz_pkg::*; #(
  parameter int POS_W = 12,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [POS_W-1:0] op,
  input  start_e           state,
  input  logic             cfg_replay,
  input  logic [IDX_W-1:0] cfg_index,
  output logic             out_a,
  output logic             out_b,
  output logic             out_z,
  output logic             held
);
  localparam int LOW_W = POS_W - IDX_W;

  logic [POS_W-1:0] zpos;
  logic             hold_now;
  logic             z_hit;

  // index sits on the A=B=1 state of its quadrature cycle
  assign zpos     = {cfg_index, LOW_W'(2)};
  assign hold_now = (state == ST_WAIT) && !cfg_replay;
  assign z_hit    = (state == ST_RUN) && (op == zpos);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_a <= !cfg_replay;
      out_b <= !cfg_replay;
      out_z <= !cfg_replay;
      held  <= !cfg_replay;
    end else begin
      held  <= hold_now;
      out_a <= hold_now | op[1];
      out_b <= hold_now | (op[1] ^ op[0]);
      out_z <= hold_now | z_hit;
    end
  end
endmodule

// File: rtl/abz_quad_gen.sv
`timescale 1ns/1ps
module abz_quad_gen import abz_pkg::*; #(
  parameter int          POS_W   = 12,
  parameter int          IDX_W   = 8,
  parameter int unsigned CLK_MHZ = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [POS_W-1:0] pos_data,
  input  logic             pos_valid,
  output logic             pos_ready,
  input  logic [1:0]       cfg_gap_sel,
  input  logic             cfg_invert,
  input  logic [IDX_W-1:0] cfg_index,
  input  logic             cfg_startup_replay,
  output logic             out_a,
  output logic             out_b,
  output logic             out_z
);
  logic [POS_W-1:0] tgt;
  logic             tgt_ok;
  logic             open;
  logic             step;
  logic [POS_W-1:0] op;
  start_e           state;
  logic             enc_held;

  assign pos_ready = 1'b1;

  abz_target #(.POS_W(POS_W)) u_tgt (
    .clk(clk), .rst_n(rst_n), .pos_data(pos_data), .pos_valid(pos_valid),
    .cfg_invert(cfg_invert), .tgt(tgt), .tgt_ok(tgt_ok)
  );

  abz_pace #(.CLK_MHZ(CLK_MHZ)) u_pace (
    .clk(clk), .rst_n(rst_n), .gap_sel(cfg_gap_sel), .step(step), .open(open)
  );

  abz_stepper #(.POS_W(POS_W)) u_step (
    .clk(clk), .rst_n(rst_n), .tgt(tgt), .tgt_ok(tgt_ok), .open(open),
    .cfg_replay(cfg_startup_replay), .op(op), .state(state), .step(step)
  );

  abz_encode #(.POS_W(POS_W), .IDX_W(IDX_W)) u_enc (
    .clk(clk), .rst_n(rst_n), .op(op), .state(state),
    .cfg_replay(cfg_startup_replay), .cfg_index(cfg_index),
    .out_a(out_a), .out_b(out_b), .out_z(out_z), .held(enc_held)
  );
endmodule

// File: rtl/abz_quad_gen_chk.sv
`timescale 1ns/1ps
module abz_quad_gen_chk import abz_pkg::*; #(
  parameter int unsigned CLK_MHZ = 200
) (
  input logic       clk,
  input logic       rst_n,
  input logic       pos_valid,
  input logic [1:0] cfg_gap_sel,
  input logic       cfg_startup_replay,
  input logic       out_a,
  input logic       out_b,
  input logic       out_z,
  input logic       held
);
  localparam int unsigned SAT = 32'h0000_FFFF;

  logic        armed, seen, pa, pb, p_held, edge_now;
  int unsigned since, gap_now;

  always_comb begin
    gap_now  = gap_cycles(cfg_gap_sel, CLK_MHZ);
    edge_now = armed && !p_held && ((out_a != pa) || (out_b != pb));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      seen   <= 1'b0;
      pa     <= 1'b0;
      pb     <= 1'b0;
      p_held <= 1'b1;
      since  <= SAT;
    end else begin
      armed  <= 1'b1;
      seen   <= seen | pos_valid;
      pa     <= out_a;
      pb     <= out_b;
      p_held <= held;
      if (edge_now) since <= 0;
      else if (since < SAT) since <= since + 1;
    end
  end

  // R2
  single_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !p_held) |-> !((out_a != pa) && (out_b != pb)));

  // R5
  edge_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_now |-> (since + 1 >= gap_now));

  // R8
  hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!seen && !cfg_startup_replay) |-> (out_a && out_b && out_z));

  // R9
  replay_z_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!seen && cfg_startup_replay) |-> !out_z);

  // R6
  z_on_11_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_z |-> (out_a && out_b));
endmodule

bind abz_quad_gen abz_quad_gen_chk #(.CLK_MHZ(CLK_MHZ)) u_chk (
  .clk(clk), .rst_n(rst_n), .pos_valid(pos_valid), .cfg_gap_sel(cfg_gap_sel),
  .cfg_startup_replay(cfg_startup_replay), .out_a(out_a), .out_b(out_b),
  .out_z(out_z), .held(enc_held)
);

// File: tb/sim_abz_quad_gen.sv
`timescale 1ns/1ps
module sim_abz_quad_gen;
  localparam int unsigned CLK_MHZ = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] pos_data = '0;
  logic        pos_valid = 1'b0;
  logic        pos_ready;
  logic [1:0]  cfg_gap_sel = 2'd1;
  logic        cfg_invert = 1'b0;
  logic [7:0]  cfg_index = '0;
  logic        cfg_startup_replay = 1'b0;
  logic        out_a, out_b, out_z;

  always #2.5 clk = ~clk;

  abz_quad_gen #(.CLK_MHZ(CLK_MHZ)) u0 (
    .clk(clk), .rst_n(rst_n), .pos_data(pos_data), .pos_valid(pos_valid),
    .pos_ready(pos_ready), .cfg_gap_sel(cfg_gap_sel), .cfg_invert(cfg_invert),
    .cfg_index(cfg_index), .cfg_startup_replay(cfg_startup_replay),
    .out_a(out_a), .out_b(out_b), .out_z(out_z)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  // monitor state
  bit          mon_en = 0;
  logic [11:0] cnt, zexp;
  logic [1:0]  pph;
  int edges, ups, downs, illegal, z_hits, z_bad, min_sp, cyc = 0, last_e;
  bit have_last;

  function automatic int exp_gap(input int s);
    int ns;
    case (s)
      0: ns = 500; 1: ns = 125; 2: ns = 8000; default: ns = 2000;
    endcase
    return (ns * CLK_MHZ / 1000 < 1) ? 1 : ns * CLK_MHZ / 1000;
  endfunction

  task automatic chk(input string req, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  always @(negedge clk) begin
    logic [1:0] ph, dl;
    cyc++;
    if (mon_en) begin
      ph = {out_a, out_a ^ out_b};
      dl = ph - pph;
      if (dl == 2'd2) illegal++;
      else if (dl != 2'd0) begin
        if (dl == 2'd1) begin cnt = cnt + 1'b1; ups++; end
        else begin cnt = cnt - 1'b1; downs++; end
        edges++;
        if (have_last && (cyc - last_e) < min_sp) min_sp = cyc - last_e;
        last_e = cyc;
        have_last = 1;
      end
      pph = ph;
      if (out_z) begin
        z_hits++;
        if (cnt != zexp || !(out_a && out_b)) z_bad++;
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic mon_start(input logic [11:0] start);
    cnt = start; pph = {out_a, out_a ^ out_b};
    edges = 0; ups = 0; downs = 0; illegal = 0; z_hits = 0; z_bad = 0;
    min_sp = 1000000; have_last = 0; mon_en = 1;
  endtask

  task automatic do_reset(input bit rep, input logic [1:0] sel, input bit inv, input logic [7:0] idx);
    mon_en = 0;
    @(posedge clk); #1;
    rst_n = 0; cfg_startup_replay = rep; cfg_gap_sel = sel; cfg_invert = inv; cfg_index = idx;
    zexp = {idx, 4'b0010};
    tick(3);
    rst_n = 1;
  endtask

  task automatic send(input logic [11:0] v);
    @(posedge clk); #1;
    pos_data = v; pos_valid = 1;
    @(posedge clk); #1;
    pos_valid = 0;
  endtask

  initial begin
    // ---------- hold mode ----------
    do_reset(0, 2'd1, 0, 8'h10);
    @(negedge clk);
    chk("R8 reset A", out_a, 1); chk("R8 reset B", out_b, 1); chk("R8 reset Z", out_z, 1);
    chk("R1 ready", pos_ready, 1);
    pos_data = 12'd999; tick(8);
    @(negedge clk);
    chk("R1 R8 unsampled data keeps hold", {out_a, out_b, out_z}, 7);
    send(12'd1234); tick(6);
    @(negedge clk);
    chk("R8 A after release", out_a, 1); chk("R8 B after release", out_b, 1);
    chk("R6 Z off index", out_z, 0);
    #1 mon_start(12'd1234);
    tick(20);
    chk("R8 no edges after release", edges, 0);
    pos_data = 12'd1300; tick(20);
    chk("R1 no valid no move", cnt, 1234);
    send(12'd1240); tick(40);
    chk("R3 hold mode track", cnt, 1240);
    chk("R3 step count", edges, 6);
    chk("R2 no double change", illegal, 0);

    // ---------- replay mode, every spacing ----------
    for (int s = 0; s < 4; s++) begin
      do_reset(1, 2'(s), 0, 8'h00);
      @(negedge clk);
      chk("R9 reset lines low", {out_a, out_b, out_z}, 0);
      #1 mon_start(12'd0);
      send(12'd200);
      tick(200 * exp_gap(s) + 40);
      chk("R9 replay reaches target", cnt, 200);
      chk("R3 replay edge count", edges, 200);
      chk("R5 min spacing", min_sp, exp_gap(s));
      chk("R2 replay gray", illegal, 0);
      chk("R9 no Z during replay", z_hits, 0);
    end

    // ---------- invert ----------
    do_reset(1, 2'd1, 1, 8'h00);
    #1 mon_start(12'd0);
    send(12'd5); tick(40);
    chk("R7 inverted target", cnt, 4091);
    chk("R3 short way down", downs, 5);
    send(12'd4000); tick(200);
    chk("R7 inverted second", cnt, 96);

    // ---------- full turns and index ----------
    do_reset(1, 2'd1, 0, 8'h00);
    #1 mon_start(12'd0);
    send(12'd0); tick(10);
    for (int k = 0; k < 3; k++) begin
      logic [7:0] ix;
      ix = (k == 0) ? 8'h00 : (k == 1) ? 8'h37 : 8'hFF;
      cfg_index = ix; zexp = {ix, 4'b0010};
      z_hits = 0; z_bad = 0;
      for (int t = 1; t <= 5; t++) begin
        send(12'((t * 1000) % 4096 == 904 ? 0 : t * 1000)); tick(1100);
      end
      chk("R3 forward turn end", cnt, 0);
      chk("R6 one Z per turn fwd", z_hits, 1);
      chk("R6 Z at index", z_bad, 0);
    end
    cfg_index = 8'h37; zexp = 12'h372; z_hits = 0; z_bad = 0;
    for (int t = 0; t < 5; t++) begin
      send(12'((t == 4) ? 0 : 3096 - t * 1000)); tick(1100);
    end
    chk("R3 backward turn end", cnt, 0);
    chk("R6 one Z per turn back", z_hits, 1);
    chk("R6 Z at index back", z_bad, 0);
    chk("R2 turns gray", illegal, 0);

    // ---------- hysteresis (last move was down) ----------
    send(12'd1); tick(20);
    chk("R4 one up after down ignored", cnt, 0);
    send(12'd2); tick(20);
    chk("R4 two up moves", cnt, 2);
    send(12'd1); tick(20);
    chk("R4 one down after up ignored", cnt, 2);
    send(12'd0); tick(20);
    chk("R4 two down moves", cnt, 0);
    #1 mon_start(12'd0);
    send(12'd2048); tick(2200);
    chk("R3 half turn target", cnt, 2048);
    chk("R3 half turn counts down", downs, 2048);

    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule